// File: doc/BRIEF.md
# Serial-Bus Synthesizer Tuning Port

This block is the write-only serial receiver that sets up a frequency synthesizer. It oversamples the bus clock and data lines with the system clock and recognises START and STOP conditions. It accepts a target address made of a fixed five-bit prefix and two low bits taken from strap pins. It then splits the data bytes that follow into three groups. The first group is a 15-bit divider word. The second is a control byte that carries pump-current and test selections. The third is a byte that turns the open-drain ports on or off.

The most significant bit of a byte in the "select" position decides which pair it opens. A 0 starts a divider pair (high part, then low part). A 1 starts a control pair (control byte, then port byte). After either pair ends, the next byte is decoded again, so one transfer can sweep the divider many times without re-addressing. The divider high part is held in a shadow register. The live divider word and its one-cycle update strobe change together, and only when the low part is complete.

Top module: `synthI2cCtrl`

## Requirements
- R1: A write address byte equal to `1100_0` followed by `addrPins[1:0]` and R/W = 0 is acknowledged. The target pulls SDA low for the ninth bus clock. Every data byte accepted after it is acknowledged the same way.
- R2: An address byte with the wrong prefix, mismatching pin bits or R/W = 1 gets no acknowledge. Every byte after it is neither acknowledged nor stored until the next START.
- R3: A select-position byte with bit 7 = 0 stores bits 6:0 as divider bits 14:8 in a shadow register only. `divWord` keeps its value if the transfer stops before the low byte.
- R4: The byte after a divider-high byte loads `divWord = {shadow, byte}`. `divStrobe` pulses high for exactly one system clock, in the cycle `divWord` takes its new value.
- R5: A select-position byte with bit 7 = 1 is a control byte. `cpHigh` = bit 6, `freqTestRoute` = bit 5, `pumpHiZ` = bit 4 and `ampOff` = bit 0. Bits 3:1 are ignored, and all three test outputs at 0 means normal operation.
- R6: The byte after a control byte sets `portOut`. Bits 7:4 and 2:0 are copied, and `portOut[3]` stays 0 whatever bit 3 holds. A 1 enables that open-drain output.
- R7: After a divider-low byte or a port byte, the next byte is again in select position. Divider and control pairs may therefore repeat in any order within one transfer, until STOP.
- R8: After reset, `divWord`, `portOut` and all control outputs are 0 (ports high-impedance, normal operation), and SDA is released.
- R9: A repeated START returns the target to address matching. A mismatching address after it blocks all further bytes of that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for oversampling |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock line |
| sdaIn | input | 1 | Bus data line (wired-AND level) |
| addrPins | input | 2 | Low address bits from strap pins |
| sdaPullDown | output | 1 | 1 pulls SDA low (acknowledge) |
| divWord | output | 15 | Active divider ratio |
| divStrobe | output | 1 | One-cycle pulse when divWord is updated |
| cpHigh | output | 1 | High charge-pump current select |
| freqTestRoute | output | 1 | Route reference/divided frequency to ports 6 and 7 |
| pumpHiZ | output | 1 | Charge pump output high-impedance |
| ampOff | output | 1 | Varicap drive amplifier disabled |
| portOut | output | 8 | Open-drain port enables, bit 3 always 0 |

## Verification
Each bus line passes two synchroniser stages and one edge register before it is seen. The receive strobes are then registered, and the output registers one clock later. Register outputs and `divStrobe` therefore settle about four system clocks after the eighth rising bus clock of a byte. The acknowledge pull-down appears about three system clocks after the falling bus clock that follows the eighth bit. The bench holds each bus half-period for eight system clocks and samples the acknowledge in the middle of the ninth high phase. It compares registers only after a STOP, and counts strobe pulses on every clock so that a pulse longer than one cycle is caught.

// File: rtl/synth_if_pkg.sv
package synth_if_pkg;

  typedef enum logic [2:0] {
    PtrIdle,
    PtrAddr,
    PtrSelect,
    PtrDivLo,
    PtrPort
  } ptrState_t;

  typedef struct packed {
    logic       loadDivHi;
    logic       loadDivLo;
    logic       loadCtrl;
    logic       loadPort;
    logic [7:0] dataByte;
  } regStrobe_t;

endpackage

// File: rtl/i2cByteCtrl.sv
module i2cByteCtrl
  import synth_if_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter int         PIN_BITS    = 2,
  parameter logic [6:0] ADDR_BASE   = 7'b1100000
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sclIn,
  input  logic                sdaIn,
  input  logic [PIN_BITS-1:0] addrPins,
  output logic                sdaPullDown,
  output regStrobe_t          loadBus
);

  localparam logic [3:0] ACK_SLOT = 4'd8;

  logic [SYNC_STAGES:0] sclSync, sdaSync;
  logic sclNow, sclPrev, sdaNow, sdaPrev;
  logic sclRise, sclFall, startSeen, stopSeen;

  ptrState_t  ptr, nextPtr;
  logic [3:0] bitCnt;
  logic [6:0] shiftReg;
  logic       ninthSeen, ackPend, accept, addrHit;
  logic [7:0] newByte;
  regStrobe_t nextLoad;

  // synchronisers: index SYNC_STAGES-1 is the current level, SYNC_STAGES the previous one
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
    end else begin
      sclSync <= {sclSync[SYNC_STAGES-1:0], sclIn};
      sdaSync <= {sdaSync[SYNC_STAGES-1:0], sdaIn};
    end
  end

  assign sclNow    = sclSync[SYNC_STAGES-1];
  assign sclPrev   = sclSync[SYNC_STAGES];
  assign sdaNow    = sdaSync[SYNC_STAGES-1];
  assign sdaPrev   = sdaSync[SYNC_STAGES];
  assign sclRise   = sclNow & ~sclPrev;
  assign sclFall   = ~sclNow & sclPrev;
  assign startSeen = sclNow & sclPrev & sdaPrev & ~sdaNow;
  assign stopSeen  = sclNow & sclPrev & ~sdaPrev & sdaNow;

  assign newByte = {shiftReg, sdaNow};
  assign addrHit = (newByte[7:PIN_BITS+1] == ADDR_BASE[6:PIN_BITS]) &&
                   (newByte[PIN_BITS:1] == addrPins) && !newByte[0];

  // byte-position decode, evaluated when the eighth bit arrives
  always_comb begin
    nextLoad          = '0;
    nextLoad.dataByte = newByte;
    accept            = 1'b0;
    nextPtr           = PtrIdle;
    case (ptr)
      PtrAddr: begin
        accept  = addrHit;
        nextPtr = addrHit ? PtrSelect : PtrIdle;
      end
      PtrSelect: begin
        accept = 1'b1;
        if (newByte[7]) begin
          nextLoad.loadCtrl = 1'b1;
          nextPtr           = PtrPort;
        end else begin
          nextLoad.loadDivHi = 1'b1;
          nextPtr            = PtrDivLo;
        end
      end
      PtrDivLo: begin
        accept             = 1'b1;
        nextLoad.loadDivLo = 1'b1;
        nextPtr            = PtrSelect;
      end
      PtrPort: begin
        accept            = 1'b1;
        nextLoad.loadPort = 1'b1;
        nextPtr           = PtrSelect;
      end
      default: begin
        accept  = 1'b0;
        nextPtr = PtrIdle;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr         <= PtrIdle;
      bitCnt      <= '0;
      shiftReg    <= '0;
      ninthSeen   <= 1'b0;
      ackPend     <= 1'b0;
      sdaPullDown <= 1'b0;
      loadBus     <= '0;
    end else begin
      loadBus <= '0;
      if (startSeen) begin
        ptr         <= PtrAddr;
        bitCnt      <= '0;
        ninthSeen   <= 1'b0;
        ackPend     <= 1'b0;
        sdaPullDown <= 1'b0;
      end else if (stopSeen) begin
        ptr         <= PtrIdle;
        bitCnt      <= '0;
        ninthSeen   <= 1'b0;
        ackPend     <= 1'b0;
        sdaPullDown <= 1'b0;
      end else if (sclRise) begin
        if (bitCnt == ACK_SLOT) begin
          ninthSeen <= 1'b1;
        end else begin
          shiftReg <= newByte[6:0];
          bitCnt   <= bitCnt + 4'd1;
          if (bitCnt == ACK_SLOT - 4'd1) begin
            ackPend <= accept;
            ptr     <= nextPtr;
            loadBus <= nextLoad;
          end
        end
      end else if (sclFall && bitCnt == ACK_SLOT) begin
        if (!ninthSeen) begin
          sdaPullDown <= ackPend;
        end else begin
          sdaPullDown <= 1'b0;
          ninthSeen   <= 1'b0;
          bitCnt      <= '0;
        end
      end
    end
  end

endmodule

// File: rtl/synthRegs.sv
module synthRegs
  import synth_if_pkg::*;
#(
  parameter int         DIV_BITS  = 15,
  parameter logic [7:0] PORT_MASK = 8'hF7
) (
  input  logic                clk,
  input  logic                rstN,
  input  regStrobe_t          loadBus,
  output logic [DIV_BITS-1:0] divWord,
  output logic                divStrobe,
  output logic                cpHigh,
  output logic                freqTestRoute,
  output logic                pumpHiZ,
  output logic                ampOff,
  output logic [7:0]          portOut
);

  localparam int HI_BITS = DIV_BITS - 8;

  logic [HI_BITS-1:0] divShadow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divShadow <= '0;
      divWord   <= '0;
      divStrobe <= 1'b0;
    end else begin
      divStrobe <= 1'b0;
      if (loadBus.loadDivHi) divShadow <= loadBus.dataByte[HI_BITS-1:0];
      if (loadBus.loadDivLo) begin
        divWord   <= {divShadow, loadBus.dataByte};
        divStrobe <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cpHigh        <= 1'b0;
      freqTestRoute <= 1'b0;
      pumpHiZ       <= 1'b0;
      ampOff        <= 1'b0;
    end else if (loadBus.loadCtrl) begin
      cpHigh        <= loadBus.dataByte[6];
      freqTestRoute <= loadBus.dataByte[5];
      pumpHiZ       <= loadBus.dataByte[4];
      ampOff        <= loadBus.dataByte[0];
    end
  end

  for (genvar k = 0; k < 8; k++) begin : g_port
    if (PORT_MASK[k]) begin : g_live
      logic portBit;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                 portBit <= 1'b0;
        else if (loadBus.loadPort) portBit <= loadBus.dataByte[k];
      end
      assign portOut[k] = portBit;
    end else begin : g_dead
      assign portOut[k] = 1'b0;
    end
  end

endmodule

// File: rtl/synthI2cCtrl.sv
module synthI2cCtrl
  import synth_if_pkg::*;
#(
  parameter int         DIV_BITS    = 15,
  parameter int         SYNC_STAGES = 2,
  parameter int         PIN_BITS    = 2,
  parameter logic [6:0] ADDR_BASE   = 7'b1100000,
  parameter logic [7:0] PORT_MASK   = 8'hF7
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sclIn,
  input  logic                sdaIn,
  input  logic [PIN_BITS-1:0] addrPins,
  output logic                sdaPullDown,
  output logic [DIV_BITS-1:0] divWord,
  output logic                divStrobe,
  output logic                cpHigh,
  output logic                freqTestRoute,
  output logic                pumpHiZ,
  output logic                ampOff,
  output logic [7:0]          portOut
);

  regStrobe_t loadBus;

  i2cByteCtrl #(
    .SYNC_STAGES(SYNC_STAGES),
    .PIN_BITS   (PIN_BITS),
    .ADDR_BASE  (ADDR_BASE)
  ) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .sclIn      (sclIn),
    .sdaIn      (sdaIn),
    .addrPins   (addrPins),
    .sdaPullDown(sdaPullDown),
    .loadBus    (loadBus)
  );

  synthRegs #(
    .DIV_BITS (DIV_BITS),
    .PORT_MASK(PORT_MASK)
  ) regs_i (
    .clk          (clk),
    .rstN         (rstN),
    .loadBus      (loadBus),
    .divWord      (divWord),
    .divStrobe    (divStrobe),
    .cpHigh       (cpHigh),
    .freqTestRoute(freqTestRoute),
    .pumpHiZ      (pumpHiZ),
    .ampOff       (ampOff),
    .portOut      (portOut)
  );

endmodule

// File: rtl/synthI2cCtrl_checker.sv
module synthI2cCtrl_checker
  import synth_if_pkg::*;
#(
  parameter int DIV_BITS = 15
) (
  input logic                clk,
  input logic                rstN,
  input logic                sclIn,
  input logic                sdaPullDown,
  input logic                divStrobe,
  input logic [DIV_BITS-1:0] divWord,
  input logic [3:0]          ctrlBits,
  input logic [7:0]          portOut,
  input regStrobe_t          loadBus
);

  // R1: acknowledge drive only begins while the bus clock is low
  a_r1_ack_starts_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaPullDown) |-> !sclIn);

  // R4: update strobe lasts a single cycle
  a_r4_strobe_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    divStrobe |=> !divStrobe);

  // R4: the divider word never moves without the strobe
  a_r4_div_moves_with_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(divWord) |-> divStrobe);

  // R5: control outputs change only after a control-byte strobe from the receiver
  a_r5_ctrl_needs_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(ctrlBits) |-> $past(loadBus.loadCtrl));

  // R6: port outputs change only after a port-byte strobe from the receiver
  a_r6_port_needs_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(portOut) |-> $past(loadBus.loadPort));

  // R7: at most one register group is addressed per received byte
  a_r7_single_target: assert property (@(posedge clk) disable iff (!rstN)
    $countones({loadBus.loadDivHi, loadBus.loadDivLo, loadBus.loadCtrl, loadBus.loadPort}) <= 1);

endmodule

bind synthI2cCtrl synthI2cCtrl_checker #(.DIV_BITS(DIV_BITS)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .sclIn      (sclIn),
  .sdaPullDown(sdaPullDown),
  .divStrobe  (divStrobe),
  .divWord    (divWord),
  .ctrlBits   ({cpHigh, freqTestRoute, pumpHiZ, ampOff}),
  .portOut    (portOut),
  .loadBus    (loadBus)
);

// File: tb/synthI2cCtrl_tb_top.sv
module synthI2cCtrl_tb_top;

  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mScl = 1'b1;
  logic mSda = 1'b1;
  logic [1:0] pins = 2'b00;

  logic        sdaPullDown, divStrobe, cpHigh, freqTestRoute, pumpHiZ, ampOff;
  logic [14:0] divWord;
  logic [7:0]  portOut;
  logic        sdaLine;

  assign sdaLine = mSda & ~sdaPullDown;

  always #10 clk = ~clk;

  synthI2cCtrl dut_i (
    .clk          (clk),
    .rstN         (rstN),
    .sclIn        (mScl),
    .sdaIn        (sdaLine),
    .addrPins     (pins),
    .sdaPullDown  (sdaPullDown),
    .divWord      (divWord),
    .divStrobe    (divStrobe),
    .cpHigh       (cpHigh),
    .freqTestRoute(freqTestRoute),
    .pumpHiZ      (pumpHiZ),
    .ampOff       (ampOff),
    .portOut      (portOut)
  );

  int checks = 0;
  int errors = 0;
  int seenStrobes = 0;
  bit done = 1'b0;

  // bench model state: 0 idle, 1 address, 2 select, 3 divider low, 4 port
  int          mPtr = 0;
  logic [6:0]  mShadow = '0;
  logic [14:0] mDiv = '0;
  logic [3:0]  mCtrl = '0;
  logic [7:0]  mPort = '0;
  int          mStrobes = 0;

  always @(posedge clk) if (rstN && divStrobe) seenStrobes++;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic startCond();
    mSda = 1'b1; waitClk(HALF);
    mScl = 1'b1; waitClk(HALF);
    mSda = 1'b0; waitClk(HALF);
    mScl = 1'b0; waitClk(HALF);
    mPtr = 1;
  endtask

  task automatic stopCond();
    mSda = 1'b0; waitClk(HALF);
    mScl = 1'b1; waitClk(HALF);
    mSda = 1'b1; waitClk(HALF);
    mPtr = 0;
  endtask

  function automatic bit expAddrHit(input logic [7:0] b);
    return (b[7:3] == 5'b11000) && (b[2:1] == pins) && !b[0];
  endfunction

  task automatic modelByte(input logic [7:0] b, output bit ack);
    ack = 1'b0;
    case (mPtr)
      1: begin ack = expAddrHit(b); mPtr = ack ? 2 : 0; end
      2: begin
        ack = 1'b1;
        if (b[7]) begin mCtrl = {b[6], b[5], b[4], b[0]}; mPtr = 4; end
        else begin mShadow = b[6:0]; mPtr = 3; end
      end
      3: begin ack = 1'b1; mDiv = {mShadow, b}; mStrobes++; mPtr = 2; end
      4: begin ack = 1'b1; mPort = b & 8'hF7; mPtr = 2; end
      default: ack = 1'b0;
    endcase
  endtask

  task automatic busByte(input logic [7:0] b, input string tag);
    bit acked, expAck;
    for (int i = 7; i >= 0; i--) begin
      mSda = b[i]; waitClk(HALF);
      mScl = 1'b1; waitClk(HALF);
      mScl = 1'b0; waitClk(4);
    end
    mSda = 1'b1; waitClk(HALF);
    mScl = 1'b1; waitClk(HALF / 2);
    acked = sdaPullDown;
    waitClk(HALF / 2);
    mScl = 1'b0; waitClk(4);
    modelByte(b, expAck);
    check(acked == expAck, tag, 32'(acked), 32'(expAck));
  endtask

  task automatic checkRegs(input string tag);
    check(divWord == mDiv, {tag, " R4 divider"}, 32'(divWord), 32'(mDiv));
    check({cpHigh, freqTestRoute, pumpHiZ, ampOff} == mCtrl, {tag, " R5 control"},
          32'({cpHigh, freqTestRoute, pumpHiZ, ampOff}), 32'(mCtrl));
    check(portOut == mPort, {tag, " R6 ports"}, 32'(portOut), 32'(mPort));
    check(seenStrobes == mStrobes, {tag, " R4 strobe count"}, 32'(seenStrobes), 32'(mStrobes));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    waitClk(3);
    // R8: reset state
    check(divWord == 15'd0 && portOut == 8'd0, "R8 reset divider/ports", 32'({divWord, portOut}), 32'd0);
    check({cpHigh, freqTestRoute, pumpHiZ, ampOff} == 4'd0, "R8 reset control", 32'({cpHigh, freqTestRoute, pumpHiZ, ampOff}), 32'd0);
    check(!sdaPullDown, "R8 reset SDA released", 32'(sdaPullDown), 32'd0);
    rstN = 1'b1;
    waitClk(4);

    // R1 R3 R4 R5 R6: full programming in one transfer
    pins = 2'b10;
    startCond();
    busByte(8'hC4, "R1 address ack");
    busByte(8'h12, "R1 R3 divider high ack");
    busByte(8'h34, "R1 R4 divider low ack");
    busByte(8'hD1, "R1 R5 control ack");
    busByte(8'hFF, "R1 R6 port ack");
    stopCond();
    waitClk(4);
    checkRegs("full");
    check(divWord == 15'h1234, "R4 divider value", 32'(divWord), 32'h1234);
    check(portOut == 8'hF7, "R6 bit 3 ignored", 32'(portOut), 32'hF7);

    // R3: divider high only leaves divWord untouched
    startCond();
    busByte(8'hC4, "R1 address ack");
    busByte(8'h05, "R3 divider high ack");
    stopCond();
    waitClk(4);
    check(divWord == 15'h1234, "R3 shadow only", 32'(divWord), 32'h1234);
    checkRegs("R3 partial");

    // R7: frequency sweep and pair repetition in one transfer
    startCond();
    busByte(8'hC4, "R1 address ack");
    busByte(8'h01, "R7 hi");
    busByte(8'h00, "R7 lo");
    busByte(8'h02, "R7 hi again");
    busByte(8'h55, "R7 lo again");
    busByte(8'h80, "R7 control after divider");
    busByte(8'h08, "R7 port");
    busByte(8'h7F, "R7 divider after port");
    busByte(8'hAA, "R7 divider low");
    stopCond();
    waitClk(4);
    check(divWord == 15'h7FAA, "R7 final divider", 32'(divWord), 32'h7FAA);
    check(portOut == 8'h00, "R6 R7 port bit 3 only", 32'(portOut), 32'h00);
    checkRegs("R7 sweep");

    // R2: wrong pins, wrong prefix, read bit
    startCond();
    busByte(8'hC6, "R2 pin mismatch no ack");
    busByte(8'h9F, "R2 ignored byte");
    busByte(8'hFF, "R2 ignored byte");
    stopCond();
    startCond();
    busByte(8'hC5, "R2 read bit no ack");
    busByte(8'h01, "R2 ignored byte");
    busByte(8'h02, "R2 ignored byte");
    stopCond();
    startCond();
    busByte(8'h44, "R2 prefix mismatch no ack");
    busByte(8'hF0, "R2 ignored byte");
    stopCond();
    waitClk(4);
    checkRegs("R2 ignored");

    // R9: repeated START re-address
    startCond();
    busByte(8'hC4, "R1 address ack");
    busByte(8'hBF, "R9 control before restart");
    startCond();
    busByte(8'hC0, "R9 wrong address after restart");
    busByte(8'h00, "R9 ignored after restart");
    startCond();
    busByte(8'hC4, "R9 readdress ack");
    busByte(8'h03, "R9 hi");
    busByte(8'h21, "R9 lo");
    stopCond();
    waitClk(4);
    check(divWord == 15'h0321, "R9 divider after restart", 32'(divWord), 32'h0321);
    checkRegs("R9 restart");

    // random transfers
    for (int t = 0; t < 40; t++) begin
      logic [7:0] addrByte;
      int nBytes;
      pins = 2'($urandom);
      addrByte = ($urandom % 5 != 0) ? {5'b11000, pins, 1'b0} : 8'($urandom);
      nBytes = 1 + ($urandom % 5);
      startCond();
      busByte(addrByte, "R1 R2 random address");
      for (int k = 0; k < nBytes; k++) begin
        busByte(8'($urandom), "R1 R7 random data");
      end
      stopCond();
      waitClk(4);
      checkRegs("random");
    end

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule